// File: doc/BRIEF.md
# Bit-Parallel Extended Shift-And Pattern Matcher

This block tracks a linear nondeterministic automaton as a vector of up to 32 state bits and advances it once for every input byte. Each state bit stands for one position in a compiled pattern. Two per-byte lookup tables say which positions may be entered from their predecessor (the advance table) and which may stay where they are (the hold table). Three global masks then close the vector over empty transitions, which covers optional and one-or-more elements. The top active position of the vector is the hit indication.

A controller outside the block compiles expressions into table contents and loads them through a write port. The tables can be rewritten while the block runs. Longer automata are split across several instances. Each instance passes its top state bit to the next one, which takes it as its entry bit when its chain link is enabled.

Top module: `shiftand_matcher`

## Requirements
- R1: A synchronous active-high `rst` clears the state vector, the begin, end and block masks, and sets the active length to 32. `matchOut` and `chainOut` are 0 on the cycle after reset.
- R2: The state advances only on a clock edge where `byteValid`, `modEn` are high and `wrEn` is low. In every other cycle the state holds, except for a length write (R8).
- R3: Advance step: T = ((S << 1) | inj) & ADV[byte] | (S & HOLD[byte]). When `chainEn` is 0, inj is a constant 1.
- R4: A state bit set in HOLD[byte] stays set while that byte repeats. This supports one-or-more runs of a character.
- R5: Empty-transition closure: with U = T | ENDM, the next state is T | (BLKM & (~(U - BEGM) ^ Df)), where Df = U and the subtraction is modulo 2^32.
- R6: `matchOut` and `chainOut` both equal state bit (len-1). They are registered and reflect a byte from the cycle after it is accepted.
- R7: When `chainEn` is 1, inj equals `chainIn` sampled in the same cycle as the byte.
- R8: State bits at or above len are cleared on every step. Writing the length clears the state. A length value of 0, or above 32, selects 32.
- R9: Write port: when `wrEn` is high, `wrSel` selects the target. 0 is ADV[wrAddr], 1 is HOLD[wrAddr], 2 is BEGM, 3 is ENDM, 4 is BLKM, and 5 is the length (wrData[5:0]). A byte presented in a write cycle is dropped.
- R10: A table rewrite takes effect on the next accepted byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| byteValid | input | 1 | Input byte strobe |
| byteIn | input | 8 | Input byte |
| modEn | input | 1 | Module enable |
| chainEn | input | 1 | Take entry bit from chainIn |
| chainIn | input | 1 | Top state bit of previous instance |
| wrEn | input | 1 | Table write strobe |
| wrSel | input | 3 | Write target select |
| wrAddr | input | 8 | Table row for advance/hold writes |
| wrData | input | 32 | Write data |
| matchOut | output | 1 | Pattern hit (top active state bit) |
| chainOut | output | 1 | Link to next instance |

## Verification
The hardest condition to reach from the ports is an interior state bit that only the closure step sets or clears. Those bits never show directly; only the top bit is visible. The bench therefore runs a full behavioural model of the 32-bit vector and compares the top bit on every clock. It first uses short hand-built patterns, then a long stream over a four-letter alphabet with random tables, masks, a short length and toggling enables. A wrong interior bit then reaches the top bit within a few bytes.

// File: rtl/sam_pkg.sv
package sam_pkg;
  typedef enum logic [2:0] {
    SEL_ADV  = 3'd0,
    SEL_HOLD = 3'd1,
    SEL_BEG  = 3'd2,
    SEL_END  = 3'd3,
    SEL_BLK  = 3'd4,
    SEL_LEN  = 3'd5
  } tblSel_e;

  typedef struct packed {
    logic step;
    logic injBit;
    logic wrAdv;
    logic wrHold;
    logic wrBeg;
    logic wrEnd;
    logic wrBlk;
    logic wrLen;
  } ctlStrb_t;
endpackage

// File: rtl/sam_ctrl.sv
module sam_ctrl
  import sam_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       byteValid,
  input  logic       modEn,
  input  logic       chainEn,
  input  logic       chainIn,
  input  logic       wrEn,
  input  logic [2:0] wrSel,
  output ctlStrb_t   strb
);
  always_comb begin
    strb        = '0;
    strb.injBit = chainEn ? chainIn : 1'b1;
    strb.step   = byteValid && modEn && !wrEn;
    if (wrEn) begin
      case (tblSel_e'(wrSel))
        SEL_ADV:  strb.wrAdv  = 1'b1;
        SEL_HOLD: strb.wrHold = 1'b1;
        SEL_BEG:  strb.wrBeg  = 1'b1;
        SEL_END:  strb.wrEnd  = 1'b1;
        SEL_BLK:  strb.wrBlk  = 1'b1;
        SEL_LEN:  strb.wrLen  = 1'b1;
        default:  ;
      endcase
    end
  end

  // R9
  wr_step_excl_chk: assert property (@(posedge clk) disable iff (rst)
    wrEn |-> !strb.step);
  // R2
  mod_gate_chk: assert property (@(posedge clk) disable iff (rst)
    !modEn |-> !strb.step);
  // R9
  one_target_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({strb.wrAdv, strb.wrHold, strb.wrBeg, strb.wrEnd, strb.wrBlk, strb.wrLen}));
endmodule

// File: rtl/sam_dpath.sv
module sam_dpath
  import sam_pkg::*;
#(
  parameter int STATE_W = 32,
  parameter int SYM_W   = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  ctlStrb_t           strb,
  input  logic [SYM_W-1:0]   byteIn,
  input  logic [SYM_W-1:0]   wrAddr,
  input  logic [STATE_W-1:0] wrData,
  output logic               topBit
);
  localparam int NSYM  = 1 << SYM_W;
  localparam int IDX_W = $clog2(STATE_W);
  localparam int LEN_W = IDX_W + 1;

  logic [STATE_W-1:0] advMem  [NSYM];
  logic [STATE_W-1:0] holdMem [NSYM];
  logic [STATE_W-1:0] stateQ, begQ, endQ, blkQ;
  logic [LEN_W-1:0]   lenQ, lenVal, topIdx;
  logic [STATE_W-1:0] lenMask, advRd, holdRd;
  logic [STATE_W-1:0] shifted, tVec, dfVec, closeVec, nextVec;

  always_ff @(posedge clk) begin
    if (strb.wrAdv)  advMem[wrAddr]  <= wrData;
    if (strb.wrHold) holdMem[wrAddr] <= wrData;
  end

  always_comb begin
    lenVal = wrData[LEN_W-1:0];
    if (lenVal == '0 || lenVal > LEN_W'(STATE_W)) lenVal = LEN_W'(STATE_W);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      begQ <= '0;
      endQ <= '0;
      blkQ <= '0;
      lenQ <= LEN_W'(STATE_W);
    end else begin
      if (strb.wrBeg) begQ <= wrData;
      if (strb.wrEnd) endQ <= wrData;
      if (strb.wrBlk) blkQ <= wrData;
      if (strb.wrLen) lenQ <= lenVal;
    end
  end

  for (genvar g = 0; g < STATE_W; g++) begin : gMask
    assign lenMask[g] = (LEN_W'(g) < lenQ);
  end

  assign advRd    = advMem[byteIn];
  assign holdRd   = holdMem[byteIn];
  assign shifted  = {stateQ[STATE_W-2:0], strb.injBit};
  assign tVec     = (shifted & advRd) | (stateQ & holdRd);
  assign dfVec    = tVec | endQ;
  assign closeVec = ~(dfVec - begQ) ^ dfVec;
  assign nextVec  = (tVec | (blkQ & closeVec)) & lenMask;

  always_ff @(posedge clk) begin
    if (rst)            stateQ <= '0;
    else if (strb.wrLen) stateQ <= '0;
    else if (strb.step)  stateQ <= nextVec;
  end

  assign topIdx = lenQ - LEN_W'(1);
  assign topBit = stateQ[topIdx[IDX_W-1:0]];

  // R1
  reset_clear_chk: assert property (@(posedge clk) rst |=> (stateQ == '0));
  // R2
  hold_state_chk: assert property (@(posedge clk) disable iff (rst)
    (!strb.step && !strb.wrLen) |=> $stable(stateQ));
  // R8
  upper_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (stateQ & ~lenMask) == '0);
  // R8
  len_range_chk: assert property (@(posedge clk) disable iff (rst)
    (lenQ >= LEN_W'(1)) && (lenQ <= LEN_W'(STATE_W)));
endmodule

// File: rtl/shiftand_matcher.sv
module shiftand_matcher
  import sam_pkg::*;
#(
  parameter int STATE_W = 32,
  parameter int SYM_W   = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               byteValid,
  input  logic [SYM_W-1:0]   byteIn,
  input  logic               modEn,
  input  logic               chainEn,
  input  logic               chainIn,
  input  logic               wrEn,
  input  logic [2:0]         wrSel,
  input  logic [SYM_W-1:0]   wrAddr,
  input  logic [STATE_W-1:0] wrData,
  output logic               matchOut,
  output logic               chainOut
);
  ctlStrb_t strb;
  logic     topBit;

  sam_ctrl ctrl_i (
    .clk(clk), .rst(rst), .byteValid(byteValid), .modEn(modEn),
    .chainEn(chainEn), .chainIn(chainIn), .wrEn(wrEn), .wrSel(wrSel),
    .strb(strb)
  );

  sam_dpath #(.STATE_W(STATE_W), .SYM_W(SYM_W)) dpath_i (
    .clk(clk), .rst(rst), .strb(strb), .byteIn(byteIn),
    .wrAddr(wrAddr), .wrData(wrData), .topBit(topBit)
  );

  assign matchOut = topBit;
  assign chainOut = topBit;
endmodule

// File: tb/shiftand_matcher_tb.sv
module shiftand_matcher_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        byteValid = 1'b0;
  logic [7:0]  byteIn = '0;
  logic        modEn = 1'b0, chainEn = 1'b0, chainIn = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  wrSel = '0;
  logic [7:0]  wrAddr = '0;
  logic [31:0] wrData = '0;
  logic        matchOut, chainOut;

  always #2 clk = ~clk;

  shiftand_matcher dut_i (
    .clk(clk), .rst(rst), .byteValid(byteValid), .byteIn(byteIn),
    .modEn(modEn), .chainEn(chainEn), .chainIn(chainIn), .wrEn(wrEn),
    .wrSel(wrSel), .wrAddr(wrAddr), .wrData(wrData),
    .matchOut(matchOut), .chainOut(chainOut)
  );

  // behavioural reference
  logic [31:0] mAdv [256];
  logic [31:0] mHold [256];
  logic [31:0] mBeg, mEnd, mBlk, mState;
  int          mLen;
  int          nChecks = 0, nFails = 0;
  bit          finished = 0;

  function automatic logic [31:0] maskOf(int len);
    logic [31:0] m = '0;
    for (int i = 0; i < len; i++) m[i] = 1'b1;
    return m;
  endfunction

  function automatic logic [31:0] refNext(logic [31:0] s, logic [7:0] b, logic inj);
    logic [31:0] t, u;
    t = (((s << 1) | {31'd0, inj}) & mAdv[b]) | (s & mHold[b]);
    u = t | mEnd;
    return (t | (mBlk & ((~(u - mBeg)) ^ u))) & maskOf(mLen);
  endfunction

  task automatic check(logic act, logic exp, string tag);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic cyc(logic bv, logic [7:0] b, logic me, logic ce, logic ci,
                     logic we, logic [2:0] sel, logic [7:0] addr, logic [31:0] d,
                     string tag);
    logic [31:0] nxt;
    logic        expTop;
    int          lv;
    @(negedge clk);
    byteValid = bv; byteIn = b; modEn = me; chainEn = ce; chainIn = ci;
    wrEn = we; wrSel = sel; wrAddr = addr; wrData = d;
    nxt = refNext(mState, b, ce ? ci : 1'b1);
    @(posedge clk);
    #1;
    if (we) begin
      case (sel)
        3'd0: mAdv[addr] = d;
        3'd1: mHold[addr] = d;
        3'd2: mBeg = d;
        3'd3: mEnd = d;
        3'd4: mBlk = d;
        3'd5: begin
          lv = int'(d[5:0]);
          mLen = (lv == 0 || lv > 32) ? 32 : lv;
          mState = '0;
        end
        default: ;
      endcase
    end else if (bv && me) begin
      mState = nxt;
    end
    expTop = mState[mLen-1];
    check(matchOut, expTop, {tag, " match"});
    check(chainOut, expTop, {tag, " chain"});
  endtask

  task automatic wr(logic [2:0] sel, logic [7:0] addr, logic [31:0] d);
    cyc(0, 0, 1, 0, 0, 1, sel, addr, d, "R9");
  endtask

  task automatic feed(string s, logic ce, logic ci, string tag);
    for (int i = 0; i < s.len(); i++) cyc(1, s[i], 1, ce, ci, 0, 0, 0, 0, tag);
  endtask

  task automatic clearTables();
    for (int a = 0; a < 256; a++) begin
      wr(0, 8'(a), 0);
      wr(1, 8'(a), 0);
    end
    wr(2, 0, 0); wr(3, 0, 0); wr(4, 0, 0);
  endtask

  initial begin
    for (int a = 0; a < 256; a++) begin mAdv[a] = '0; mHold[a] = '0; end
    mBeg = '0; mEnd = '0; mBlk = '0; mState = '0; mLen = 32;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    #1;
    // R1 reset state
    check(matchOut, 1'b0, "R1 reset match");
    check(chainOut, 1'b0, "R1 reset chain");
    clearTables();

    // R3 exact sequence "abc"
    wr(5, 0, 3);
    wr(0, "a", 32'h1); wr(0, "b", 32'h2); wr(0, "c", 32'h4);
    feed("xab", 0, 0, "R3");
    check(matchOut, 1'b0, "R6 before final byte");
    feed("c", 0, 0, "R3");
    check(matchOut, 1'b1, "R6 hit after c");
    feed("abx", 0, 0, "R3");
    check(matchOut, 1'b0, "R3 mismatch clears");

    // R2 modEn low and byteValid low hold state
    feed("ab", 0, 0, "R2");
    cyc(1, "c", 0, 0, 0, 0, 0, 0, 0, "R2 modEn low");
    check(matchOut, 1'b0, "R2 disabled byte ignored");
    cyc(0, "c", 1, 0, 0, 0, 0, 0, 0, "R2 no valid");
    cyc(1, "c", 1, 0, 0, 0, 0, 0, 0, "R2");
    check(matchOut, 1'b1, "R2 state held across idle");

    // R9 byte dropped in write cycle
    feed("ab", 0, 0, "R9");
    cyc(1, "c", 1, 0, 0, 1, 3'd2, 0, 0, "R9 write drops byte");
    check(matchOut, 1'b0, "R9 dropped byte no hit");
    feed("c", 0, 0, "R9");
    check(matchOut, 1'b1, "R9 state kept through write");

    // R10 rewrite takes effect
    wr(0, "c", 32'h0);
    feed("abc", 0, 0, "R10");
    check(matchOut, 1'b0, "R10 removed entry");
    wr(0, "c", 32'h4);

    // R4 one-or-more via hold table
    wr(1, "b", 32'h2);
    feed("abbbbc", 0, 0, "R4");
    check(matchOut, 1'b1, "R4 repeated b then c");
    feed("ac", 0, 0, "R4");
    check(matchOut, 1'b0, "R4 needs at least one b");

    // R5 closure masks
    wr(2, 0, 32'h2); wr(3, 0, 32'h4); wr(4, 0, 32'h6);
    feed("acabcxabbcaac", 0, 0, "R5");
    wr(2, 0, 32'h1); wr(3, 0, 32'h2); wr(4, 0, 32'h3);
    feed("cbacbbcaxc", 0, 0, "R5");
    wr(2, 0, 0); wr(3, 0, 0); wr(4, 0, 0); wr(1, "b", 0);

    // R7 chained entry
    wr(5, 0, 2);
    feed("ab", 1, 0, "R7");
    check(matchOut, 1'b0, "R7 chainIn low blocks entry");
    feed("a", 1, 1, "R7");
    feed("b", 1, 0, "R7");
    check(matchOut, 1'b1, "R7 chainIn high enters");

    // R8 length 0 means 32, top bit 31
    wr(5, 0, 0);
    wr(0, "z", 32'hFFFF_FFFF);
    for (int i = 0; i < 31; i++) feed("z", 0, 0, "R8");
    check(matchOut, 1'b0, "R8 31 bytes no hit");
    feed("z", 0, 0, "R8");
    check(matchOut, 1'b1, "R8 bit 31 after 32 bytes");
    wr(5, 0, 40);
    check(matchOut, 1'b0, "R8 length write clears");
    wr(5, 0, 5);
    for (int i = 0; i < 5; i++) feed("z", 0, 0, "R8");
    check(matchOut, 1'b1, "R8 len 5 top bit 4");

    // random tables and stream
    wr(5, 0, 12);
    for (int a = 0; a < 4; a++) begin
      wr(0, 8'("a" + a), $urandom);
      wr(1, 8'("a" + a), $urandom & $urandom);
    end
    wr(2, 0, $urandom); wr(3, 0, $urandom); wr(4, 0, $urandom);
    for (int i = 0; i < 3000; i++) begin
      cyc(($urandom % 8) != 0, 8'("a" + ($urandom % 4)), ($urandom % 10) != 0,
          ($urandom % 3) == 0, $urandom % 2, 0, 0, 0, 0, "R5 R7 random");
      if (i % 500 == 499) begin
        wr(1, 8'("a" + ($urandom % 4)), $urandom);
        wr(4, 0, $urandom);
      end
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end
endmodule